// File: doc/BRIEF.md
# Flash Erase/Program Suspend Controller

This block holds the operation state of a serial flash device. It tracks whether an erase or a program is running, suspended or idle, and it drives the busy and suspend status bits. A front end that has already decoded the serial command stream hands it one 8-bit opcode at a time. For each opcode the block answers accepted or rejected. While an erase is suspended, or while a program is suspended, a different set of opcodes is rejected.

Suspend latency is modelled by a cycle count, `TSUS`. Once a suspend is accepted, the suspend bit rises at once, but busy stays high for `TSUS` more cycles. After a resume, a second count keeps new suspends out for the same number of cycles. The array's own erase and program timing is not modelled here. A `work_done` pulse reports that the running operation has finished. Loss of power is modelled by the asynchronous reset, which drops any suspend.

Top module: `flash_suspend_ctrl`

## Requirements
- R1: While and after reset (`rst_n` low), `busy`, `sus`, `op_accept` and `op_reject` are all 0.
- R2: Each cycle with `op_valid` high is followed, one cycle later, by exactly one of `op_accept`/`op_reject` for one cycle. Neither is raised otherwise.
- R3: Opcodes start operations only when `busy` is 0. Sector/block erase is 20h, 52h, D8h or 44h. Chip erase is C7h or 60h. Program is 02h, 32h or 42h. Accepting one of these sets `busy`. A `work_done` pulse ends the running operation and clears `busy`.
- R4: While `busy` is 1, only the status read 05h and a valid suspend 75h are accepted. Any other opcode is rejected and changes no state. Suspend is accepted only when `busy` is 1, `sus` is 0, the suspend latency has ended, and a sector/block erase or a program is running. Otherwise it is rejected.
- R5: A suspend issued during a chip erase is rejected, and `sus` stays 0.
- R6: `sus` rises in the cycle after an accepted suspend. `busy` stays 1 for exactly `TSUS` cycles after that and then falls to 0.
- R7: While an erase is suspended, 01h and all erase opcodes (20h, 52h, D8h, 44h, C7h, 60h) are rejected. A program opcode is accepted and sets `busy` with `sus` still 1. A suspend during that program is rejected.
- R8: While a program is suspended, 01h and the program opcodes 02h, 32h and 42h are rejected. Reads such as 03h, 0Bh and 05h are accepted.
- R9: Resume (7Ah) is accepted only while `sus` is 1 and `busy` is 0. It clears `sus`, sets `busy`, and restores the suspended operation, which `work_done` later ends. A resume when `sus` is 0 is rejected.
- R10: A suspend presented d cycles after an accepted resume is rejected when d ≤ `TSUS`. It is accepted when d = `TSUS`+1 and the other conditions hold.
- R11: A reset while suspended clears `sus` and `busy`. A following resume is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also the power-loss event |
| op_valid | input | 1 | An opcode is presented this cycle |
| op_code | input | 8 | Decoded opcode |
| work_done | input | 1 | Running erase/program has finished |
| op_accept | output | 1 | Previous opcode accepted |
| op_reject | output | 1 | Previous opcode ignored |
| busy | output | 1 | Operation running or suspend still settling |
| sus | output | 1 | An erase or program is suspended |

## Verification
The assertions check, on every cycle, the rules that hold locally. There is one answer per opcode. `busy` is still high when `sus` rises. `busy` is set again when `sus` falls. A chip erase never leads to a suspend. No suspend lands inside the post-resume guard window. A nested program keeps `sus` set. The bench scenarios cover what needs a full sequence: the exact cycle on which `busy` falls after a suspend, the rejection sets that differ between erase suspend and program suspend, the exact boundary of the guard window, and the loss of a suspend on reset.

// File: rtl/flash_suspend_ctrl.sv
module flash_suspend_ctrl #(
  parameter int TSUS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [7:0] op_code,
  input  logic       work_done,
  output logic       op_accept,
  output logic       op_reject,
  output logic       busy,
  output logic       sus
);
  localparam int CW = $clog2(TSUS + 1);

  typedef enum logic [1:0] {K_NONE, K_ERASE, K_CHIP, K_PROG} kind_t;

  kind_t         kind, skind;
  logic          sus_q, acc_q, rej_q;
  logic [CW-1:0] lat, guard;

  logic is_sus, is_res, is_wrsr, is_rdsr, is_ers, is_chip, is_prog;
  logic blocked, sus_ok, take;

  assign is_sus  = op_code == 8'h75;
  assign is_res  = op_code == 8'h7A;
  assign is_wrsr = op_code == 8'h01;
  assign is_rdsr = op_code == 8'h05;
  assign is_ers  = op_code inside {8'h20, 8'h52, 8'hD8, 8'h44};
  assign is_chip = op_code inside {8'hC7, 8'h60};
  assign is_prog = op_code inside {8'h02, 8'h32, 8'h42};

  assign busy    = (kind != K_NONE) || (lat != '0);
  assign blocked = is_wrsr || ((skind == K_PROG) ? is_prog : (is_ers || is_chip));
  assign sus_ok  = !sus_q && lat == '0 && guard == '0 &&
                   (kind == K_ERASE || kind == K_PROG);
  assign take    = busy  ? (is_rdsr || (is_sus && sus_ok)) :
                   sus_q ? (!is_sus && !blocked) :
                           (!is_sus && !is_res);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind  <= K_NONE;
      skind <= K_NONE;
      sus_q <= 1'b0;
      lat   <= '0;
      guard <= '0;
      acc_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      acc_q <= op_valid && take;
      rej_q <= op_valid && !take;
      if (lat != '0) lat <= lat - 1'b1;
      if (guard != '0) guard <= guard - 1'b1;
      if (work_done && kind != K_NONE) kind <= K_NONE;
      if (op_valid && take) begin
        if (is_sus) begin
          sus_q <= 1'b1;
          skind <= kind;
          kind  <= K_NONE;
          lat   <= CW'(TSUS);
        end else if (is_res) begin
          sus_q <= 1'b0;
          kind  <= skind;
          skind <= K_NONE;
          guard <= CW'(TSUS);
        end else if (is_ers) begin
          kind <= K_ERASE;
        end else if (is_chip) begin
          kind <= K_CHIP;
        end else if (is_prog) begin
          kind <= K_PROG;
        end
      end
    end
  end

  assign op_accept = acc_q;
  assign op_reject = rej_q;
  assign sus       = sus_q;

  a_r2_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (op_accept ^ op_reject));
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !(op_accept || op_reject));
  a_r6_sus_before_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sus) |-> (busy && $past(busy)));
  a_r5_chip_no_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_CHIP && !sus) |=> !sus);
  a_r10_guard_window: assert property (@(posedge clk) disable iff (!rst_n)
    (guard != '0) |=> !$rose(sus));
  a_r9_resume_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sus) |-> busy);
  a_r7_nested_keeps_sus: assert property (@(posedge clk) disable iff (!rst_n)
    (sus && !busy && skind == K_ERASE && op_valid && is_prog) |=> (sus && busy));
endmodule

// File: tb/flash_suspend_ctrl_bench.sv
module flash_suspend_ctrl_bench;
  localparam int TSUS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [7:0] op_code = 8'h00;
  logic work_done = 1'b0;
  logic op_accept, op_reject, busy, sus;
  int tests = 0;
  int fails = 0;

  always #2ns clk = ~clk;

  flash_suspend_ctrl #(.TSUS(TSUS)) u_flash_suspend_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .work_done(work_done), .op_accept(op_accept), .op_reject(op_reject),
    .busy(busy), .sus(sus));

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c, input int exp_acc, input string req);
    op_valid = 1'b1;
    op_code  = c;
    @(negedge clk);
    op_valid = 1'b0;
    chk(req, $sformatf("accept %02h", c), int'(op_accept), exp_acc);
    chk(req, $sformatf("reject %02h", c), int'(op_reject), 1 - exp_acc);
  endtask

  task automatic done_pulse();
    work_done = 1'b1;
    @(negedge clk);
    work_done = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "sus", int'(sus), 0);
    chk("R1", "answers", int'(op_accept | op_reject), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after", int'(busy), 0);
  endtask

  task automatic t_idle_ops();
    do_reset();
    send(8'h75, 0, "R4");
    send(8'h7A, 0, "R9");
    chk("R9", "sus", int'(sus), 0);
    send(8'h52, 1, "R3");
    chk("R3", "busy", int'(busy), 1);
    send(8'h03, 0, "R4");
    send(8'h05, 1, "R4");
    @(negedge clk);
    chk("R2", "quiet", int'(op_accept | op_reject), 0);
    done_pulse();
    chk("R3", "busy done", int'(busy), 0);
  endtask

  task automatic t_chip();
    do_reset();
    send(8'h60, 1, "R5");
    send(8'h75, 0, "R5");
    chk("R5", "sus", int'(sus), 0);
    chk("R5", "busy", int'(busy), 1);
    done_pulse();
    chk("R5", "busy done", int'(busy), 0);
  endtask

  task automatic t_erase_suspend();
    do_reset();
    send(8'h20, 1, "R3");
    send(8'h75, 1, "R6");
    chk("R6", "sus", int'(sus), 1);
    chk("R6", "busy", int'(busy), 1);
    for (int j = 1; j < TSUS; j++) begin
      @(negedge clk);
      chk("R6", "busy hold", int'(busy), 1);
    end
    @(negedge clk);
    chk("R6", "busy fall", int'(busy), 0);
    send(8'h01, 0, "R7");
    send(8'hD8, 0, "R7");
    send(8'hC7, 0, "R7");
    send(8'h44, 0, "R7");
    send(8'h03, 1, "R7");
    send(8'h02, 1, "R7");
    chk("R7", "nested busy", int'(busy), 1);
    chk("R7", "nested sus", int'(sus), 1);
    send(8'h75, 0, "R7");
    done_pulse();
    chk("R7", "nested end", int'(busy), 0);
    chk("R7", "sus kept", int'(sus), 1);
    send(8'h7A, 1, "R9");
    chk("R9", "sus", int'(sus), 0);
    chk("R9", "busy", int'(busy), 1);
    done_pulse();
    chk("R9", "resumed end", int'(busy), 0);
  endtask

  task automatic t_prog_suspend();
    do_reset();
    send(8'h32, 1, "R3");
    send(8'h75, 1, "R8");
    repeat (TSUS) @(negedge clk);
    chk("R8", "busy", int'(busy), 0);
    send(8'h01, 0, "R8");
    send(8'h02, 0, "R8");
    send(8'h42, 0, "R8");
    send(8'h0B, 1, "R8");
    send(8'h05, 1, "R8");
    chk("R8", "sus", int'(sus), 1);
    send(8'h7A, 1, "R9");
    chk("R9", "busy", int'(busy), 1);
    send(8'h7A, 0, "R9");
    done_pulse();
    chk("R9", "idle", int'(busy), 0);
  endtask

  task automatic t_guard();
    do_reset();
    send(8'hD8, 1, "R10");
    send(8'h75, 1, "R10");
    repeat (TSUS) @(negedge clk);
    send(8'h7A, 1, "R10");
    repeat (TSUS - 1) @(negedge clk);
    send(8'h75, 0, "R10");
    chk("R10", "sus early", int'(sus), 0);
    send(8'h75, 1, "R10");
    chk("R10", "sus late", int'(sus), 1);
  endtask

  task automatic t_powerloss();
    do_reset();
    send(8'h02, 1, "R11");
    send(8'h75, 1, "R11");
    chk("R11", "sus set", int'(sus), 1);
    do_reset();
    chk("R11", "sus", int'(sus), 0);
    chk("R11", "busy", int'(busy), 0);
    send(8'h7A, 0, "R11");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle_ops();
    t_chip();
    t_erase_suspend();
    t_prog_suspend();
    t_guard();
    t_powerloss();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule